// File: doc/BRIEF.md
# DSP Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each cycle it can multiply two 16-bit operands and write the product into one of two 40-bit accumulators. It can instead add the product to that accumulator, subtract the product from it, clear it, or move its contents through a bidirectional barrel shifter. Every operation takes one clock: the new accumulator value and its flags are visible at the outputs right after the edge that accepts the operation.

The operands are widened to 17 bits before the multiply. Signed mode extends them with their sign bit and unsigned mode pads them with zeros. In fractional mode the product is doubled, so two 1.15 operands give a 1.31 result. Above bit 31 of each accumulator sit eight guard bits. A registered overflow flag shows when a result spills into those guard bits. When saturation is on, an overflowing result is clamped to the largest or smallest 1.31 value and a sticky saturation flag is set for that accumulator.

Top module: `dsp_mac_engine`

## Requirements
- R1: After reset both accumulators read zero and all six flags (ovf_a, ovf_b, ovf_any, sat_a, sat_b, sat_any) are low.
- R2: Operation code 3 (multiply) in integer mode (frac_mode=0) loads the selected accumulator with the product of the two operands. Each operand is sign-extended to 17 bits when signed_mode=1 and zero-extended when signed_mode=0. The value is visible one clock after the operation is accepted.
- R3: With frac_mode=1 the product is doubled (shifted left one bit) before it is used by multiply, add or subtract.
- R4: Code 1 adds the product to the accumulator chosen by acc_sel (0 = A, 1 = B), and code 2 subtracts the product from it. The other accumulator and its flags do not change.
- R5: Nothing changes while op_valid is low. Code 0 and the unused codes 6 and 7 change nothing even when op_valid is high.
- R6: Every write from codes 1, 2, 3 or 5 forms a 41-bit result and sets the target's overflow flag exactly when bits 40 down to 31 of that result are not all equal. ovf_any is ovf_a OR ovf_b.
- R7: If sat_en=1 and the result overflows, the accumulator takes 0x007FFFFFFF for a positive result and 0xFF80000000 for a negative one, and its sticky saturation flag is set. If sat_en=0, the accumulator keeps the low 40 bits of the result.
- R8: A saturation flag stays set through later operations until code 4 (clear) targets its accumulator. Code 4 zeroes that accumulator and both of its flags. sat_any is sat_a OR sat_b.
- R9: Code 5 shifts the selected accumulator. The amount is shift_amt read as a 6-bit two's-complement value: positive shifts left, negative shifts right arithmetically. The 41-bit result goes through the overflow and saturation rules of R6 and R7.
- R10: A shift amount whose magnitude is above 16 acts as a shift of 16 in the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 3 | 0 none, 1 add, 2 subtract, 3 multiply, 4 clear, 5 shift |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| opa | input | 16 | Multiplier operand |
| opb | input | 16 | Multiplicand operand |
| signed_mode | input | 1 | 1: operands signed, 0: unsigned |
| frac_mode | input | 1 | 1: fractional (product doubled), 0: integer |
| sat_en | input | 1 | Enable saturation of the written result |
| shift_amt | input | 6 | Two's-complement shift amount, positive = left |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A's last result used its guard bits |
| ovf_b | output | 1 | B's last result used its guard bits |
| ovf_any | output | 1 | OR of the overflow flags |
| sat_a | output | 1 | Sticky: A has saturated |
| sat_b | output | 1 | Sticky: B has saturated |
| sat_any | output | 1 | OR of the saturation flags |

## Verification
The multiply is swept over every pairing of eight corner operands: zero, one, minus one, the largest and smallest 16-bit values, a mid-range value, a power of two and a negative half scale. Each pairing is run in all four combinations of signed/unsigned and integer/fractional, which separates the two extension rules and the fractional doubling. A long chain of additions of the largest fractional product runs first below the guard bits, then into them, then past bit 39 with saturation off, which checks both the overflow flag and the 40-bit wrap. A run of subtractions with saturation on hits the negative clamp and shows the flag staying sticky. Every shift amount from -32 to +31 is applied to one positive and one negative value, which checks the direction, the arithmetic right fill and the clamp of the shift magnitude.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [2:0] {
      MAC_NOP = 3'd0,
      MAC_ADD = 3'd1,
      MAC_SUB = 3'd2,
      MAC_MPY = 3'd3,
      MAC_CLR = 3'd4,
      MAC_SHF = 3'd5
   } mac_op_e;
endpackage

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
   parameter int OP_W  = 16,
   parameter int EXT_W = 41
) (
   input  logic [OP_W-1:0]         a,
   input  logic [OP_W-1:0]         b,
   input  logic                    signed_mode,
   input  logic                    frac_mode,
   output logic signed [EXT_W-1:0] prod
);
   localparam int MW = OP_W + 1;
   localparam int PW = 2 * MW;
   localparam int FW = PW + 1;

   if (EXT_W < FW) begin : g_bad_width
      $error("mac_multiplier: EXT_W too narrow for the doubled product");
   end

   logic signed [MW-1:0] ax, bx;
   logic signed [PW-1:0] raw;
   logic signed [FW-1:0] aligned;

   always_comb begin
      ax      = {signed_mode & a[OP_W-1], a};
      bx      = {signed_mode & b[OP_W-1], b};
      raw     = ax * bx;
      aligned = frac_mode ? {raw, 1'b0} : {raw[PW-1], raw};
   end

   if (EXT_W > FW) begin : g_extend
      assign prod = {{(EXT_W-FW){aligned[FW-1]}}, aligned};
   end else begin : g_exact
      assign prod = aligned;
   end
endmodule

// File: rtl/mac_shifter.sv
module mac_shifter #(
   parameter int EXT_W     = 41,
   parameter int SHAMT_W   = 6,
   parameter int SHIFT_MAX = 16
) (
   input  logic signed [EXT_W-1:0] din,
   input  logic [SHAMT_W-1:0]      amt,
   output logic signed [EXT_W-1:0] dout
);
   localparam int STAGES = $clog2(SHIFT_MAX + 1);

   if (SHIFT_MAX >= (1 << (SHAMT_W - 1)) || SHAMT_W <= STAGES) begin : g_bad_amt
      $error("mac_shifter: SHAMT_W cannot express +/-SHIFT_MAX");
   end

   logic               go_left;
   logic [SHAMT_W:0]   mag_raw;
   logic [STAGES-1:0]  mag;
   logic signed [EXT_W-1:0] stage [STAGES+1];

   always_comb begin
      go_left = ~amt[SHAMT_W-1];
      mag_raw = go_left ? {1'b0, amt} : ({1'b0, ~amt} + (SHAMT_W+1)'(1));
      mag     = (mag_raw > (SHAMT_W+1)'(SHIFT_MAX)) ? STAGES'(SHIFT_MAX)
                                                    : mag_raw[STAGES-1:0];
   end

   assign stage[0] = din;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      assign stage[k+1] = !mag[k] ? stage[k]
                        : (go_left ? (stage[k] <<< (1 << k))
                                   : (stage[k] >>> (1 << k)));
   end

   assign dout = stage[STAGES];
endmodule

// File: rtl/mac_saturator.sv
module mac_saturator #(
   parameter int ACC_W    = 40,
   parameter int EXT_W    = 41,
   parameter int PROD_TOP = 31
) (
   input  logic signed [EXT_W-1:0] res,
   input  logic                    sat_en,
   output logic [ACC_W-1:0]        val,
   output logic                    ovf,
   output logic                    sat_hit
);
   localparam int HI_W = ACC_W - PROD_TOP;
   localparam logic [ACC_W-1:0] POS_LIM = {{HI_W{1'b0}}, {PROD_TOP{1'b1}}};
   localparam logic [ACC_W-1:0] NEG_LIM = {{HI_W{1'b1}}, {PROD_TOP{1'b0}}};

   if (EXT_W != ACC_W + 1 || PROD_TOP >= ACC_W) begin : g_bad_cfg
      $error("mac_saturator: inconsistent widths");
   end

   logic [EXT_W-1-PROD_TOP:0] upper;

   always_comb begin
      upper   = res[EXT_W-1:PROD_TOP];
      ovf     = !((&upper) || !(|upper));
      sat_hit = sat_en && ovf;
      if (sat_hit) val = res[EXT_W-1] ? NEG_LIM : POS_LIM;
      else         val = res[ACC_W-1:0];
   end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine #(
   parameter int OP_W      = 16,
   parameter int GUARD_W   = 8,
   parameter int SHAMT_W   = 6,
   parameter int SHIFT_MAX = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   input  logic [2:0]             op_code,
   input  logic                   acc_sel,
   input  logic [OP_W-1:0]        opa,
   input  logic [OP_W-1:0]        opb,
   input  logic                   signed_mode,
   input  logic                   frac_mode,
   input  logic                   sat_en,
   input  logic [SHAMT_W-1:0]     shift_amt,
   output logic [2*OP_W+GUARD_W-1:0] acc_a,
   output logic [2*OP_W+GUARD_W-1:0] acc_b,
   output logic                   ovf_a,
   output logic                   ovf_b,
   output logic                   ovf_any,
   output logic                   sat_a,
   output logic                   sat_b,
   output logic                   sat_any
);
   import mac_pkg::*;

   localparam int ACC_W    = 2*OP_W + GUARD_W;
   localparam int EXT_W    = ACC_W + 1;
   localparam int PROD_TOP = 2*OP_W - 1;
   localparam int NUM_ACC  = 2;

   if (GUARD_W < 2) begin : g_bad_guard
      $error("dsp_mac_engine: at least two guard bits are needed");
   end

   mac_op_e op;
   assign op = mac_op_e'(op_code);

   logic [ACC_W-1:0]        acc_q [NUM_ACC];
   logic                    ovf_q [NUM_ACC];
   logic                    sat_q [NUM_ACC];

   logic signed [EXT_W-1:0] cur_ext, prod, shifted, result;
   logic [ACC_W-1:0]        wr_val;
   logic                    wr_ovf, wr_sat, do_write, do_clear;

   assign cur_ext = {acc_q[acc_sel][ACC_W-1], acc_q[acc_sel]};

   mac_multiplier #(.OP_W(OP_W), .EXT_W(EXT_W)) u_mul (
      .a(opa), .b(opb), .signed_mode(signed_mode), .frac_mode(frac_mode),
      .prod(prod)
   );

   mac_shifter #(.EXT_W(EXT_W), .SHAMT_W(SHAMT_W), .SHIFT_MAX(SHIFT_MAX)) u_shf (
      .din(cur_ext), .amt(shift_amt), .dout(shifted)
   );

   always_comb begin
      do_write = 1'b0;
      do_clear = 1'b0;
      result   = prod;
      case (op)
         MAC_ADD: begin result = cur_ext + prod; do_write = op_valid; end
         MAC_SUB: begin result = cur_ext - prod; do_write = op_valid; end
         MAC_MPY: begin result = prod;           do_write = op_valid; end
         MAC_SHF: begin result = shifted;        do_write = op_valid; end
         MAC_CLR: do_clear = op_valid;
         default: ;
      endcase
   end

   mac_saturator #(.ACC_W(ACC_W), .EXT_W(EXT_W), .PROD_TOP(PROD_TOP)) u_sat (
      .res(result), .sat_en(sat_en), .val(wr_val), .ovf(wr_ovf), .sat_hit(wr_sat)
   );

   for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
      logic hit;
      assign hit = (acc_sel == 1'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q[i] <= '0;
            ovf_q[i] <= 1'b0;
            sat_q[i] <= 1'b0;
         end else if (hit && do_clear) begin
            acc_q[i] <= '0;
            ovf_q[i] <= 1'b0;
            sat_q[i] <= 1'b0;
         end else if (hit && do_write) begin
            acc_q[i] <= wr_val;
            ovf_q[i] <= wr_ovf;
            if (wr_sat) sat_q[i] <= 1'b1;
         end
      end
   end

   assign acc_a   = acc_q[0];
   assign acc_b   = acc_q[1];
   assign ovf_a   = ovf_q[0];
   assign ovf_b   = ovf_q[1];
   assign sat_a   = sat_q[0];
   assign sat_b   = sat_q[1];
   assign ovf_any = ovf_q[0] | ovf_q[1];
   assign sat_any = sat_q[0] | sat_q[1];
endmodule

// File: rtl/mac_engine_checks.sv
module mac_engine_checks #(
   parameter int ACC_W    = 40,
   parameter int PROD_TOP = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [2:0]       op_code,
   input logic             acc_sel,
   input logic [ACC_W-1:0] acc_a,
   input logic [ACC_W-1:0] acc_b,
   input logic             ovf_a,
   input logic             ovf_b,
   input logic             sat_a,
   input logic             sat_b
);
   localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-PROD_TOP){1'b0}}, {PROD_TOP{1'b1}}};
   localparam logic [ACC_W-1:0] NEG_LIM = {{(ACC_W-PROD_TOP){1'b1}}, {PROD_TOP{1'b0}}};

   logic clr_a, clr_b;
   assign clr_a = op_valid && op_code == 3'd4 && !acc_sel;
   assign clr_b = op_valid && op_code == 3'd4 &&  acc_sel;

   a_r4_a_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && acc_sel) |=> ($stable(acc_a) && $stable(ovf_a) && $stable(sat_a)));

   a_r4_b_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !acc_sel) |=> ($stable(acc_b) && $stable(ovf_b) && $stable(sat_b)));

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(acc_a) && $stable(acc_b)));

   a_r7_clamp_a: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_a) |-> (acc_a == POS_LIM || acc_a == NEG_LIM));

   a_r7_clamp_b: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_b) |-> (acc_b == POS_LIM || acc_b == NEG_LIM));

   a_r8_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_a && !clr_a) |=> sat_a);

   a_r8_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_b && !clr_b) |=> sat_b);

   a_r8_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
      clr_a |=> (acc_a == '0 && !ovf_a && !sat_a));

   a_r8_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
      clr_b |=> (acc_b == '0 && !ovf_b && !sat_b));
endmodule

bind dsp_mac_engine mac_engine_checks #(.ACC_W(ACC_W), .PROD_TOP(PROD_TOP)) u_checks (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .acc_sel(acc_sel), .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a),
   .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b)
);

// File: tb/dsp_mac_engine_test.sv
module dsp_mac_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic        acc_sel = 1'b0;
   logic [15:0] opa = '0, opb = '0;
   logic        signed_mode = 1'b0, frac_mode = 1'b0, sat_en = 1'b0;
   logic [5:0]  shift_amt = '0;
   logic [39:0] acc_a, acc_b;
   logic        ovf_a, ovf_b, ovf_any, sat_a, sat_b, sat_any;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   logic [39:0] m_acc [2];
   bit          m_ovf [2];
   bit          m_sat [2];

   always #4 clk = ~clk;

   dsp_mac_engine uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc_sel(acc_sel), .opa(opa), .opb(opb), .signed_mode(signed_mode),
      .frac_mode(frac_mode), .sat_en(sat_en), .shift_amt(shift_amt),
      .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b),
      .ovf_any(ovf_any), .sat_a(sat_a), .sat_b(sat_b), .sat_any(sat_any)
   );

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            finish_run();
         end
      end
   end

   task automatic model_step(int op, int sel, logic [15:0] a, logic [15:0] b,
                             bit sm, bit fm, bit se, int sh, bit vld);
      longint ea, eb, p, cur, r, top;
      int n;
      bit ov;
      if (!vld) return;
      ea  = sm ? longint'($signed(a)) : longint'(a);
      eb  = sm ? longint'($signed(b)) : longint'(b);
      p   = ea * eb;
      if (fm) p = p * 2;
      cur = longint'($signed(m_acc[sel]));
      case (op)
         1: r = cur + p;
         2: r = cur - p;
         3: r = p;
         4: begin m_acc[sel] = '0; m_ovf[sel] = 0; m_sat[sel] = 0; return; end
         5: begin
               n = (sh > 16) ? 16 : ((sh < -16) ? -16 : sh);
               r = (n >= 0) ? (cur <<< n) : (cur >>> (-n));
            end
         default: return;
      endcase
      r   = (r <<< 23) >>> 23;
      top = r >>> 31;
      ov  = (top != 0) && (top != -1);
      if (ov && se) begin
         m_acc[sel] = (r < 0) ? 40'hFF80000000 : 40'h007FFFFFFF;
         m_sat[sel] = 1;
      end else begin
         m_acc[sel] = r[39:0];
      end
      m_ovf[sel] = ov;
   endtask

   task automatic compare(string tag);
      n_checks++;
      if (acc_a !== m_acc[0] || acc_b !== m_acc[1] || ovf_a !== m_ovf[0] ||
          ovf_b !== m_ovf[1] || sat_a !== m_sat[0] || sat_b !== m_sat[1] ||
          ovf_any !== (m_ovf[0] | m_ovf[1]) || sat_any !== (m_sat[0] | m_sat[1])) begin
         n_fail++;
         $display("FAIL %s: actual a=%h b=%h ovf=%b%b%b sat=%b%b%b expected a=%h b=%h ovf=%b%b%b sat=%b%b%b",
                  tag, acc_a, acc_b, ovf_a, ovf_b, ovf_any, sat_a, sat_b, sat_any,
                  m_acc[0], m_acc[1], m_ovf[0], m_ovf[1], m_ovf[0] | m_ovf[1],
                  m_sat[0], m_sat[1], m_sat[0] | m_sat[1]);
      end
   endtask

   task automatic apply(int op, int sel, logic [15:0] a, logic [15:0] b,
                        bit sm, bit fm, bit se, int sh, bit vld, string tag);
      @(negedge clk);
      op_valid = vld; op_code = 3'(op); acc_sel = sel[0]; opa = a; opb = b;
      signed_mode = sm; frac_mode = fm; sat_en = se; shift_amt = 6'(sh);
      model_step(op, sel, a, b, sm, fm, se, sh, vld);
      @(negedge clk);
      op_valid = 1'b0;
      compare(tag);
   endtask

   logic [15:0] pat [8];

   initial begin
      pat = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
              16'h8000, 16'h1234, 16'h0100, 16'hC000};
      for (int s = 0; s < 2; s++) begin
         m_acc[s] = '0; m_ovf[s] = 0; m_sat[s] = 0;
      end
      repeat (3) @(negedge clk);
      compare("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset release");

      // R2 / R3: multiply sweep over corner operands and all mode pairs
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++)
            for (int m = 0; m < 4; m++)
               apply(3, (i + j) % 2, pat[i], pat[j], m[0], m[1], 1'b0, 0, 1'b1,
                     m[1] ? "R3 fractional multiply" : "R2 integer multiply");

      apply(4, 0, 0, 0, 0, 0, 0, 0, 1, "R8 clear A");
      apply(4, 1, 0, 0, 0, 0, 0, 0, 1, "R8 clear B");

      // R4 / R6 / R7: accumulate largest fractional product, no saturation
      for (int k = 0; k < 300; k++)
         apply(1, 0, 16'h7FFF, 16'h7FFF, 1, 1, 0, 0, 1,
               (k < 1) ? "R4 accumulate" : ((k < 256) ? "R6 guard overflow" : "R7 wrap without saturation"));

      // R5: invalid or idle operations leave state alone
      apply(1, 0, 16'h7FFF, 16'h7FFF, 1, 1, 0, 0, 0, "R5 op_valid low");
      apply(6, 0, 16'h1234, 16'h1234, 1, 0, 1, 3, 1, "R5 code 6");
      apply(7, 1, 16'h1234, 16'h1234, 1, 0, 1, 3, 1, "R5 code 7");
      apply(0, 1, 16'h1234, 16'h1234, 1, 0, 1, 3, 1, "R5 code 0");

      // R4 / R7 / R8: subtract into B with saturation
      apply(3, 1, 16'h0003, 16'h0005, 1, 0, 1, 0, 1, "R2 small load B");
      for (int k = 0; k < 4; k++)
         apply(2, 1, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 1, "R7 negative clamp");
      apply(3, 1, 16'h0002, 16'h0003, 1, 0, 1, 0, 1, "R8 sticky after small multiply");
      apply(1, 1, 16'h8000, 16'h8000, 1, 1, 1, 0, 1, "R7 positive clamp");
      apply(4, 1, 0, 0, 0, 0, 0, 0, 1, "R8 clear B drops sticky");
      apply(4, 0, 0, 0, 0, 0, 0, 0, 1, "R8 clear A");

      // R9 / R10: every shift amount on a positive and a negative value
      for (int sh = -32; sh < 32; sh++)
         for (int v = 0; v < 2; v++) begin
            apply(3, v, v ? 16'hEDCB : 16'h1234, 16'h0567, 1, 0, 0, 0, 1, "R2 shift preload");
            apply(5, v, 0, 0, 0, 0, sh[0], sh, 1,
                  (sh > 16 || sh < -16) ? "R10 shift clamp" : "R9 shift");
         end

      finish_run();
   end
endmodule